// File: doc/BRIEF.md
# Remapping Enable Command Controller

This block turns address remapping on or off for a stream of DMA requests when software asks for it. Software writes a one-bit command into a 32-bit command register. The block does not apply the new mode straight away. It first stops taking new requests and waits until every request already accepted has completed. It then switches the remap mode while no transaction is in flight, and only after that does it raise or clear a separate status bit that software can poll.

The request path uses a valid/ready handshake. The block keeps its own count of outstanding requests: it adds one for each accepted request and takes one away for each completion. The current mode appears on `req_remap_o` and applies to every request accepted while it is shown. A command that arrives while a switch is already under way is held, and it is acted on once that switch has finished.

Top module: `remap_enable_ctrl`

## Requirements
- R1: A write with `reg_sel_i`=0 reaches the command register. Bit 31 of the write data requests the mode (1 = enable, 0 = disable), and all other bits are ignored. A read with `reg_sel_i`=0 always returns 32'h0.
- R2: A read with `reg_sel_i`=1 returns the mode now in effect in bit 31 and zeros in bits 30:0. Writes with `reg_sel_i`=1 have no effect. The status bit changes only when a switch completes.
- R3: A command write whose bit 31 differs from the status holds `req_ready_o` low from the next cycle until the switch completes. With no outstanding requests, `req_ready_o` is low for exactly two cycles and the new status is visible two cycles after the write cycle.
- R4: The outstanding count rises on each accepted request and falls on each completion. While it is non-zero, a pending switch waits and `req_ready_o` stays low.
- R5: `req_remap_o` equals the status bit. It changes only after a cycle in which `req_ready_o` was low and the outstanding count was zero, so no accepted request ever sees the mode change.
- R6: A command write that matches the current status completes at once. It does not lower `req_ready_o` and does not change the status.
- R7: After reset the status is 0, `req_remap_o` is 0, `req_ready_o` is 1 and both register reads return 0.
- R8: Command writes that arrive during a switch are held, and the last one wins. When the switch completes, a held value that differs from the new status starts another switch. Otherwise the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = command, 1 = status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for the selected register |
| req_valid_i | input | 1 | DMA request valid |
| req_ready_o | output | 1 | DMA request accepted when high with valid |
| req_remap_o | output | 1 | Remap mode applied to the request accepted this cycle |
| cpl_valid_i | input | 1 | One outstanding request has completed |

## Verification
The assertions check on every cycle that the mode changes only after a stalled cycle with zero outstanding requests, that a drain with requests still in flight cannot move on, that matching writes leave the block idle, and that the read data holds only the defined bit. Only the bench scenarios can show the exact stall length for an idle path, that a drain is held open by outstanding traffic and released once the last completion arrives, and how held commands resolve. Those scenarios cover last-wins overwrites, a held value equal to the new status, and a held value that starts a second switch.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRAIN  = 2'd1,
    ST_SWITCH = 2'd2,
    ST_DONE   = 2'd3
  } remap_state_e;
endpackage

// File: rtl/remap_outstanding_ctr.sv
module remap_outstanding_ctr #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/remap_cmd_hold.sv
module remap_cmd_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic clr_i,
  input  logic val_i,
  output logic vld_o,
  output logic val_o
);
  logic vld_q, val_q;

  // clear wins: the fsm consumes a same-cycle write directly
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      val_q <= 1'b0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end else if (cap_i) begin
      vld_q <= 1'b1;
      val_q <= val_i;
    end
  end

  assign vld_o = vld_q;
  assign val_o = val_q;
endmodule

// File: rtl/remap_mode_fsm.sv
module remap_mode_fsm
  import remap_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_wr_i,
  input  logic         cmd_val_i,
  input  logic         hold_vld_i,
  input  logic         hold_val_i,
  input  logic         drained_i,
  output remap_state_e state_o,
  output logic         mode_o,
  output logic         ready_o,
  output logic         hold_cap_o,
  output logic         hold_clr_o
);
  remap_state_e state_q, state_d;
  logic mode_q, mode_d, tgt_q, tgt_d;
  logic nxt_vld, nxt_val;

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    tgt_d      = tgt_q;
    hold_cap_o = 1'b0;
    hold_clr_o = 1'b0;
    nxt_vld    = cmd_wr_i | hold_vld_i;
    nxt_val    = cmd_wr_i ? cmd_val_i : hold_val_i;
    case (state_q)
      ST_IDLE: begin
        if (cmd_wr_i && (cmd_val_i != mode_q)) begin
          tgt_d   = cmd_val_i;
          state_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        hold_cap_o = cmd_wr_i;
        if (drained_i) state_d = ST_SWITCH;
      end
      ST_SWITCH: begin
        hold_cap_o = cmd_wr_i;
        mode_d     = tgt_q;
        state_d    = ST_DONE;
      end
      default: begin
        hold_clr_o = 1'b1;
        if (nxt_vld && (nxt_val != mode_q)) begin
          tgt_d   = nxt_val;
          state_d = ST_DRAIN;
        end else begin
          state_d = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      tgt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      tgt_q   <= tgt_d;
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign ready_o = (state_q == ST_IDLE) || (state_q == ST_DONE);
endmodule

// File: rtl/remap_enable_ctrl.sv
module remap_enable_ctrl
  import remap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EN_BIT = 31,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  output logic              req_remap_o,
  input  logic              cpl_valid_i
);
  localparam logic SEL_CMD = 1'b0;

  remap_state_e     state_q;
  logic             mode_q, ready, accept, cmd_wr;
  logic             hold_vld, hold_val, hold_cap, hold_clr;
  logic [CNT_W-1:0] out_cnt;
  logic             drained;

  assign cmd_wr = reg_wr_i && (reg_sel_i == SEL_CMD);
  assign accept = req_valid_i && ready;

  remap_outstanding_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (accept),
    .dec_i (cpl_valid_i),
    .cnt_o (out_cnt),
    .zero_o(drained)
  );

  remap_cmd_hold u_hold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (hold_cap),
    .clr_i (hold_clr),
    .val_i (reg_wdata_i[EN_BIT]),
    .vld_o (hold_vld),
    .val_o (hold_val)
  );

  remap_mode_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_wr_i  (cmd_wr),
    .cmd_val_i (reg_wdata_i[EN_BIT]),
    .hold_vld_i(hold_vld),
    .hold_val_i(hold_val),
    .drained_i (drained),
    .state_o   (state_q),
    .mode_o    (mode_q),
    .ready_o   (ready),
    .hold_cap_o(hold_cap),
    .hold_clr_o(hold_clr)
  );

  // command register is write-only: reads as zero
  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i != SEL_CMD) reg_rdata_o[EN_BIT] = mode_q;
  end

  assign req_ready_o = ready;
  assign req_remap_o = mode_q;
endmodule

// File: rtl/remap_enable_ctrl_chk.sv
module remap_enable_ctrl_chk
  import remap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EN_BIT = 31,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic              reg_sel_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              req_ready_o,
  input logic              req_remap_o,
  input remap_state_e      state_q,
  input logic [CNT_W-1:0]  out_cnt
);
  p_cmd_reads_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_i |-> reg_rdata_o == '0);

  p_status_spare_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_i |-> (reg_rdata_o & ~({{(DATA_W-1){1'b0}}, 1'b1} << EN_BIT)) == '0);

  p_drain_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN && out_cnt != '0) |=> state_q == ST_DRAIN);

  p_busy_stalls_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DRAIN) |-> !req_ready_o);

  p_switch_when_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(req_remap_o) |-> ($past(!req_ready_o) && $past(out_cnt == '0)));

  p_match_no_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && reg_wr_i && !reg_sel_i && reg_wdata_i[EN_BIT] == req_remap_o)
    |=> (state_q == ST_IDLE && req_ready_o));
endmodule

bind remap_enable_ctrl remap_enable_ctrl_chk #(
  .DATA_W(DATA_W), .EN_BIT(EN_BIT), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_sel_i  (reg_sel_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .req_ready_o(req_ready_o),
  .req_remap_o(req_remap_o),
  .state_q    (state_q),
  .out_cnt    (out_cnt)
);

// File: tb/remap_enable_ctrl_test.sv
`timescale 1ns/1ps
module remap_enable_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_i = 1'b0, reg_sel_i = 1'b1;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0, req_ready_o, req_remap_o, cpl_valid_i = 1'b0;

  int checks = 0, fails = 0;
  // model: 0 idle, 1 drain, 2 switch, 3 done
  int m_state = 0, m_cnt = 0, m_tgt = 0, m_stat = 0, m_hv = 0, m_hval = 0;
  bit req_on = 0, cpl_on = 0;

  always #2.5 clk = ~clk;

  remap_enable_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o), .req_remap_o(req_remap_o), .cpl_valid_i(cpl_valid_i)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_ready();
    return (m_state == 0 || m_state == 3) ? 1 : 0;
  endfunction

  task automatic model_step();
    int acc, cw, w, cnt_old, nv, nval;
    acc = (req_valid_i && m_ready() != 0) ? 1 : 0;
    cw = (reg_wr_i && !reg_sel_i) ? 1 : 0;
    w = int'(reg_wdata_i[31]);
    cnt_old = m_cnt;
    m_cnt = m_cnt + acc - (cpl_valid_i ? 1 : 0);
    case (m_state)
      0: if (cw != 0 && w != m_stat) begin m_tgt = w; m_state = 1; end
      1: begin
        if (cw != 0) begin m_hv = 1; m_hval = w; end
        if (cnt_old == 0) m_state = 2;
      end
      2: begin
        if (cw != 0) begin m_hv = 1; m_hval = w; end
        m_stat = m_tgt; m_state = 3;
      end
      default: begin
        nv = (cw != 0 || m_hv != 0) ? 1 : 0;
        nval = (cw != 0) ? w : m_hval;
        m_hv = 0;
        if (nv != 0 && nval != m_stat) begin m_tgt = nval; m_state = 1; end
        else m_state = 0;
      end
    endcase
  endtask

  task automatic compare();
    logic [31:0] exp_rd;
    exp_rd = reg_sel_i ? (32'(m_stat) << 31) : 32'h0;
    chk(req_ready_o == m_ready(), "R3 ready", req_ready_o, m_ready());
    chk(req_remap_o == m_stat, "R5 remap", req_remap_o, m_stat);
    chk(reg_rdata_o == exp_rd, reg_sel_i ? "R2 status" : "R1 cmd read", reg_rdata_o, exp_rd);
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    req_valid_i = req_on && (m_cnt < 12);
    cpl_valid_i = cpl_on && (m_cnt > 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    cycle();
    reg_wr_i = 1'b0; reg_sel_i = 1'b1; reg_wdata_i = '0;
  endtask

  task automatic settle();
    for (int i = 0; i < 300 && !(m_state == 0 && req_ready_o); i++) cycle();
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(req_ready_o == 1'b1, "R7 ready", req_ready_o, 1);
    chk(req_remap_o == 1'b0, "R7 remap", req_remap_o, 0);
    chk(reg_rdata_o == 32'h0, "R7 status read", reg_rdata_o, 0);
    reg_sel_i = 1'b0; #0.1;
    chk(reg_rdata_o == 32'h0, "R7 cmd read", reg_rdata_o, 0);
    reg_sel_i = 1'b1;
    rst_n = 1'b1;
    run(3);

    // R3: idle path, two stall cycles, status after two cycles
    wr(1'b0, 32'h8000_0000);
    chk(req_ready_o == 1'b0, "R3 stall 1", req_ready_o, 0);
    cycle();
    chk(req_ready_o == 1'b0, "R3 stall 2", req_ready_o, 0);
    cycle();
    chk(reg_rdata_o == 32'h8000_0000, "R3 status set", reg_rdata_o, 32'h8000_0000);
    chk(req_ready_o == 1'b1, "R3 ready back", req_ready_o, 1);
    run(2);

    // R6: matching write, no stall
    wr(1'b0, 32'h8000_0000);
    chk(req_ready_o == 1'b1, "R6 no stall", req_ready_o, 1);
    run(2);

    // R1: low bits ignored; R2: status writes ignored
    wr(1'b0, 32'h7FFF_FFFF);
    settle();
    chk(reg_rdata_o == 32'h0, "R1 low bits ignored", reg_rdata_o, 0);
    wr(1'b1, 32'hFFFF_FFFF);
    run(3);
    chk(req_remap_o == 1'b0, "R2 status write ignored", req_remap_o, 0);

    // R4: drain held open by outstanding requests
    req_on = 1; cpl_on = 0;
    run(6);
    req_on = 0;
    wr(1'b0, 32'h8000_0000);
    run(5);
    chk(req_ready_o == 1'b0, "R4 drain waits", req_ready_o, 0);
    chk(req_remap_o == 1'b0, "R4 mode held", req_remap_o, 0);
    cpl_on = 1;
    settle();
    chk(req_remap_o == 1'b1, "R4 switched after drain", req_remap_o, 1);
    cpl_on = 0;

    // R8: last-wins hold equal to new status -> idle
    req_on = 1; run(3); req_on = 0;
    wr(1'b0, 32'h0);
    wr(1'b0, 32'h8000_0000);
    wr(1'b0, 32'h0);
    cpl_on = 1;
    settle();
    chk(req_remap_o == 1'b0, "R8 last wins", req_remap_o, 0);

    // R8: held value differs -> second switch
    req_on = 1; cpl_on = 0; run(3); req_on = 0;
    wr(1'b0, 32'h8000_0000);
    wr(1'b0, 32'h0);
    cpl_on = 1;
    for (int i = 0; i < 50 && m_stat == 0; i++) cycle();
    chk(req_remap_o == 1'b1, "R8 first switch", req_remap_o, 1);
    settle();
    chk(req_remap_o == 1'b0, "R8 second switch", req_remap_o, 0);

    // mixed traffic with toggles
    req_on = 1; cpl_on = 1;
    for (int k = 0; k < 12; k++) begin
      wr(1'b0, (k % 3 == 0) ? 32'h0 : 32'h8000_0000);
      run(k % 5);
      cpl_on = (k % 2 == 0);
    end
    req_on = 0; cpl_on = 1;
    settle();
    run(20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule